// File: doc/BRIEF.md
# Keyboard Command Responder Queue

This block stands in for the keyboard end of a serial channel. Bytes sent toward the keyboard arrive as commands. Two of them trigger canned answers: a reset answer of three bytes and a layout answer of two bytes. Key events arrive as a 7-bit key index with a release flag. Each event is turned into a 7-bit code through a parameterised 128-entry table, and the release flag becomes bit 7 of the byte. All bytes, from answers and from keys alike, go into one 256-byte queue. The host drains that queue one byte per read.

All three data paths use valid/ready handshakes.
- **Command input.** `cmd_ready` is low while an answer is being emitted. A command is taken only in a cycle where `cmd_valid` and `cmd_ready` are both high.
- **Key input.** A key event is taken only when `key_valid` and `key_ready` are both high. `key_ready` follows `cmd_ready`.
- **Read side.** It never stalls. `rd_valid` says the queue holds data, and `rd_data` shows the oldest byte. A cycle with `rd_ready` high is a read.
  - If the queue is empty, that read returns zero and changes nothing.
  - If the queue is full, a push is dropped without notice.

Top module: `kbd_reply_queue`

## Requirements
- R1: After reset `rd_valid` is 0, `rd_data` is 0x00, and `cmd_ready` and `key_ready` are both 1.
- R2: The queue is first-in first-out with room for DEPTH (256) bytes. While `rd_valid` is 1, `rd_data` shows the oldest byte, and a cycle with `rd_ready` high removes that byte at the clock edge.
- R3: A push that finds DEPTH bytes already held, judged on the occupancy at the start of the cycle, is discarded. The queue contents are unchanged, apart from any pop made in the same cycle.
- R4: While the queue is empty, `rd_data` is 0x00. A read in that state changes neither the contents nor the occupancy.
- R5: When command 0x01 is accepted, the bytes 0xFF, 0xFF, 0x05 are pushed in that order, one per cycle, on the three clock edges after acceptance. `cmd_ready` is low for exactly those three cycles.
- R6: When command 0x07 is accepted, the bytes 0xFE, 0x20 are pushed in that order on the two clock edges after acceptance. `cmd_ready` is low for exactly those two cycles.
- R7: Any other command value is accepted and pushes nothing, and `cmd_ready` stays 1 in the next cycle.
- R8: An accepted key event pushes one byte. Bits 6:0 are the table entry for the index and bit 7 is the release flag (1 = release, 0 = press). The default table entry for index i is (5*i+3) mod 128. An entry of zero (index 25) still pushes a byte, 0x00 or 0x80.
- R9: `rd_valid` is 1 exactly when the queue holds at least one byte. It rises in the cycle after a successful push into an empty queue, and stays 1 after a read that leaves bytes behind.
- R10: A successful push and a read of a non-empty queue in the same cycle leave the occupancy unchanged. The read returns the oldest byte, not the new one.
- R11: `key_ready` equals `cmd_ready`. While an answer is in progress, key events are not accepted and push nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte offered |
| cmd_ready | output | 1 | Command accepted this cycle if valid; low while an answer is emitted |
| cmd_data | input | 8 | Command byte |
| key_valid | input | 1 | Key event offered |
| key_ready | output | 1 | Key event accepted this cycle if valid |
| key_index | input | 7 | Key index into the translation table |
| key_release | input | 1 | 1 for a release, 0 for a press |
| rd_valid | output | 1 | Queue holds at least one byte |
| rd_ready | input | 1 | Read strobe; pops the oldest byte when the queue is not empty |
| rd_data | output | 8 | Oldest byte, or 0x00 when the queue is empty |

## Verification
The bench targets the following corner cases:
- **Full queue.** It fills the queue to exactly 256 bytes, then keeps pushing. A design that let the write pointer run past the read pointer would overwrite the oldest byte, and the drain order would break.
- **Empty queue.** It reads while empty. A design that advanced the read pointer on an empty read would later return stale or misordered bytes.
- **Same-cycle push and read.** It pushes and reads in the same cycle. A wrong occupancy update would show as `rd_valid` dropping early or staying high too long.
- **Answer in progress.** It offers key events and commands while an answer is being emitted. A design without the hold-off would interleave key codes into the answer.
- **Zero table entry.** It uses the key index whose table entry is zero. A design that treated a zero code as "no push" would leave `rd_valid` low.

// File: rtl/kbdq_pkg.sv
package kbdq_pkg;
  localparam int BYTE_W    = 8;
  localparam int CODE_W    = BYTE_W - 1;
  localparam int KEY_COUNT = 1 << CODE_W;
  localparam int KIDX_W    = $clog2(KEY_COUNT);
  localparam int MAX_REPLY = 3;
  localparam int STEP_W    = $clog2(MAX_REPLY + 1);

  localparam logic [BYTE_W-1:0] CMD_RESET  = 8'h01;
  localparam logic [BYTE_W-1:0] CMD_LAYOUT = 8'h07;

  typedef enum logic [1:0] {
    RPL_NONE   = 2'd0,
    RPL_RESET  = 2'd1,
    RPL_LAYOUT = 2'd2
  } reply_e;

  function automatic reply_e decode_cmd(logic [BYTE_W-1:0] b);
    case (b)
      CMD_RESET:  return RPL_RESET;
      CMD_LAYOUT: return RPL_LAYOUT;
      default:    return RPL_NONE;
    endcase
  endfunction

  function automatic logic [STEP_W-1:0] reply_len(reply_e k);
    case (k)
      RPL_RESET:  return STEP_W'(3);
      RPL_LAYOUT: return STEP_W'(2);
      default:    return '0;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] reply_byte(reply_e k, logic [STEP_W-1:0] i);
    case (k)
      RPL_RESET:  return (i == STEP_W'(2)) ? 8'h05 : 8'hFF;
      RPL_LAYOUT: return (i == '0) ? 8'hFE : 8'h20;
      default:    return '0;
    endcase
  endfunction

  function automatic logic [KEY_COUNT*CODE_W-1:0] default_keymap();
    logic [KEY_COUNT*CODE_W-1:0] m;
    m = '0;
    for (int i = 0; i < KEY_COUNT; i++) begin
      m[i*CODE_W +: CODE_W] = CODE_W'((5 * i + 3) % KEY_COUNT);
    end
    return m;
  endfunction
endpackage

// File: rtl/kbdq_keymap.sv
module kbdq_keymap
  import kbdq_pkg::*;
#(
  parameter logic [KEY_COUNT*CODE_W-1:0] MAP = default_keymap()
) (
  input  logic [KIDX_W-1:0] idx,
  input  logic              release_flag,
  output logic [BYTE_W-1:0] code
);
  logic [CODE_W-1:0] entry;

  always_comb begin
    entry = MAP[int'(idx)*CODE_W +: CODE_W];
    code  = {release_flag, entry};
  end
endmodule

// File: rtl/kbdq_reply_seq.sv
module kbdq_reply_seq
  import kbdq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [BYTE_W-1:0] cmd_data,
  output logic              idle,
  output logic              push_valid,
  output logic [BYTE_W-1:0] push_byte
);
  reply_e            kind_q;
  reply_e            kind_d;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] left_q;

  assign kind_d     = decode_cmd(cmd_data);
  assign idle       = (left_q == '0);
  assign push_valid = !idle;
  assign push_byte  = reply_byte(kind_q, step_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= RPL_NONE;
      step_q <= '0;
      left_q <= '0;
    end else if (push_valid) begin
      step_q <= step_q + 1'b1;
      left_q <= left_q - 1'b1;
    end else if (cmd_valid && kind_d != RPL_NONE) begin
      kind_q <= kind_d;
      step_q <= '0;
      left_q <= reply_len(kind_d);
    end
  end
endmodule

// File: rtl/kbdq_fifo.sv
module kbdq_fifo #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] head,
  output logic [CW-1:0] occ
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr, wptr_nxt, rptr_nxt;
  logic          do_wr, do_rd;

  assign do_wr = wr_en && (occ != CW'(DEPTH));
  assign do_rd = rd_en && (occ != '0);
  assign head  = mem[rptr];

  generate
    if (DEPTH == (1 << AW)) begin : g_pow2
      always_comb begin
        wptr_nxt = wptr + 1'b1;
        rptr_nxt = rptr + 1'b1;
      end
    end else begin : g_wrap
      always_comb begin
        wptr_nxt = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
        rptr_nxt = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else begin
      if (do_wr) wptr <= wptr_nxt;
      if (do_rd) rptr <= rptr_nxt;
      case ({do_wr, do_rd})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/kbd_reply_queue.sv
module kbd_reply_queue
  import kbdq_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter logic [KEY_COUNT*CODE_W-1:0] KEYMAP = default_keymap(),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [BYTE_W-1:0] cmd_data,
  input  logic              key_valid,
  output logic              key_ready,
  input  logic [KIDX_W-1:0] key_index,
  input  logic              key_release,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [BYTE_W-1:0] rd_data
);
  logic              seq_idle, seq_push;
  logic [BYTE_W-1:0] seq_byte, key_code, push_data, head;
  logic              push_req;
  logic [CW-1:0]     occ;

  kbdq_reply_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_data  (cmd_data),
    .idle      (seq_idle),
    .push_valid(seq_push),
    .push_byte (seq_byte)
  );

  kbdq_keymap #(.MAP(KEYMAP)) u_map (
    .idx         (key_index),
    .release_flag(key_release),
    .code        (key_code)
  );

  assign cmd_ready = seq_idle;
  assign key_ready = seq_idle;
  assign push_req  = seq_push || (key_valid && seq_idle);
  assign push_data = seq_push ? seq_byte : key_code;

  kbdq_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (push_req),
    .wr_data(push_data),
    .rd_en  (rd_ready),
    .head   (head),
    .occ    (occ)
  );

  assign rd_valid = (occ != '0);
  assign rd_data  = rd_valid ? head : '0;
endmodule

// File: rtl/kbd_reply_queue_chk.sv
module kbd_reply_queue_chk #(
  parameter int DEPTH = 256,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [7:0]    cmd_data,
  input logic          key_ready,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [7:0]    rd_data,
  input logic          push_req,
  input logic [CW-1:0] occ
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && occ == CW'(DEPTH) && !rd_ready) |=> occ == CW'(DEPTH));

  p_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == 8'h00);

  p_reset_reply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_data == 8'h01)
      |=> !cmd_ready ##1 !cmd_ready ##1 !cmd_ready ##1 cmd_ready);

  p_layout_reply_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_data == 8'h07)
      |=> !cmd_ready ##1 !cmd_ready ##1 cmd_ready);

  p_other_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_data != 8'h01 && cmd_data != 8'h07) |=> cmd_ready);

  p_push_avail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && occ < CW'(DEPTH)) |=> rd_valid);

  p_balanced_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && rd_ready && rd_valid && occ < CW'(DEPTH)) |=> $stable(occ));

  p_busy_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |-> !key_ready);
endmodule

bind kbd_reply_queue kbd_reply_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_data (cmd_data),
  .key_ready(key_ready),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_data  (rd_data),
  .push_req (push_req),
  .occ      (occ)
);

// File: tb/kbd_reply_queue_tb.sv
module kbd_reply_queue_tb;
  localparam int DEPTH = 256;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid, cmd_ready, key_valid, key_ready, key_release;
  logic       rd_valid, rd_ready;
  logic [7:0] cmd_data, rd_data;
  logic [6:0] key_index;

  always #4 clk = ~clk;

  kbd_reply_queue u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .key_valid(key_valid), .key_ready(key_ready),
    .key_index(key_index), .key_release(key_release),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string tag = "R1";

  int mq [DEPTH];
  int mhead = 0, mcnt = 0;
  int pend [3];
  int pend_n = 0, pend_i = 0;

  function automatic int exp_code(int idx, bit rel);
    return (rel ? 128 : 0) + ((5 * idx + 3) % 128);
  endfunction

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit cv, int cd, bit kv, int ki, bit kr, bit rr);
    bit mready, push;
    int pb, pre, tail;
    @(negedge clk);
    cmd_valid = cv; cmd_data = 8'(cd);
    key_valid = kv; key_index = 7'(ki); key_release = kr;
    rd_ready = rr;
    #1;
    mready = (pend_i == pend_n);
    chk("rd_valid", int'(rd_valid), int'(mcnt != 0));
    chk("rd_data", int'(rd_data), (mcnt != 0) ? mq[mhead] : 0);
    chk("cmd_ready", int'(cmd_ready), int'(mready));
    chk("key_ready", int'(key_ready), int'(mready));
    push = 0; pb = 0;
    if (!mready) begin
      push = 1; pb = pend[pend_i]; pend_i++;
    end else if (kv) begin
      push = 1; pb = exp_code(ki, kr);
    end
    pre = mcnt;
    tail = (mhead + pre) % DEPTH;
    if (push && pre < DEPTH) begin mq[tail] = pb; mcnt++; end
    if (rr && pre > 0) begin mhead = (mhead + 1) % DEPTH; mcnt--; end
    if (mready && cv) begin
      if (cd == 1) begin pend = '{8'hFF, 8'hFF, 8'h05}; pend_n = 3; pend_i = 0; end
      else if (cd == 7) begin pend = '{8'hFE, 8'h20, 0}; pend_n = 2; pend_i = 0; end
    end
    @(posedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic drain();
    while (mcnt > 0) cyc(0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    rst_n = 0; cmd_valid = 0; cmd_data = 0; key_valid = 0;
    key_index = 0; key_release = 0; rd_ready = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;

    tag = "R1"; idle(2);

    // R5: reset command answer, with keys offered while busy (R11)
    tag = "R5"; cyc(1, 1, 0, 0, 0, 0);
    tag = "R11"; cyc(1, 7, 1, 10, 0, 0); cyc(0, 0, 1, 11, 1, 0); cyc(0, 0, 1, 12, 0, 0);
    tag = "R5"; idle(1); chk("count after reset answer", mcnt, 3); drain();

    // R6: layout query answer
    tag = "R6"; cyc(1, 7, 0, 0, 0, 0); idle(3); drain();

    // R7: unknown commands ignored
    tag = "R7"; cyc(1, 8'h33, 0, 0, 0, 0); cyc(1, 8'h00, 0, 0, 0, 0); cyc(1, 8'hFF, 0, 0, 0, 0); idle(2);

    // R8: key translation, including zero entry at index 25
    tag = "R8";
    cyc(0, 0, 1, 25, 0, 0); cyc(0, 0, 1, 25, 1, 0);
    cyc(0, 0, 1, 0, 0, 0);  cyc(0, 0, 1, 127, 1, 0); idle(1); drain();

    // R4: reads on an empty queue
    tag = "R4"; cyc(0, 0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0, 1); idle(1);

    // R10: push and read together
    tag = "R10";
    cyc(0, 0, 1, 3, 0, 0); cyc(0, 0, 1, 4, 1, 1); cyc(0, 0, 1, 5, 0, 1);
    cyc(0, 0, 0, 0, 0, 1); idle(1);
    // R9: read leaving bytes keeps rd_valid
    tag = "R9"; cyc(0, 0, 1, 6, 0, 0); cyc(0, 0, 1, 7, 0, 0); cyc(0, 0, 0, 0, 0, 1); idle(1); drain();

    // R3: fill to DEPTH, overflow pushes, full push plus read
    tag = "R3";
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 1, i % 128, i[7], 0);
    chk("model full", mcnt, DEPTH);
    cyc(0, 0, 1, 50, 1, 0); cyc(1, 1, 0, 0, 0, 0); idle(3);
    cyc(0, 0, 1, 60, 0, 1); cyc(0, 0, 1, 61, 0, 0);
    tag = "R2"; drain(); idle(1);

    // R2: constrained random mix
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 4000; i++) begin
      int r, cdv;
      r = int'($urandom_range(0, 99));
      cdv = (r < 8) ? 1 : (r < 14) ? 7 : int'($urandom_range(0, 255));
      cyc(r < 20, cdv, $urandom_range(0, 9) < 6, int'($urandom_range(0, 127)),
          1'($urandom_range(0, 1)), $urandom_range(0, 9) < 4);
    end
    drain(); idle(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule